// File: doc/BRIEF.md
# Run-time Programmable Montgomery Multiplier over GF(2^m)

This block multiplies two elements of a binary extension field GF(2^m) whose degree and defining polynomial arrive with each operation rather than being fixed at build time. One datapath sized for degree 8 serves every field of degree 1 to 8. The degree and the polynomial are sampled with the operands on a start strobe.

The block returns the Montgomery product A(x)·B(x)·x^(-m) mod p(x). A caller that needs the ordinary product first multiplies one operand by the correction constant x^m mod p(x). The factor x^(-m) then cancels, and the same datapath gives plain field products.

By default the unit is bit-serial and takes one step per degree, so m steps per operation. A parameter turns it into a combinational array of 8 chained steps, which has a fixed latency of one cycle.

Top module: `gf_mont_mul`

## Requirements
- R1: When `done` is high, `result` equals the unique polynomial r of degree below m with r·x^m ≡ A·B (mod p), for every m from 1 to 8.
- R2: Bits 0..m-1 of `poly_in` give the low coefficients of p(x). The coefficient of x^m is taken as 1 whatever bit m of `poly_in` holds, and bits above m are ignored.
- R3: Bits at position m and above of `a_in` and `b_in` are ignored.
- R4: Bits of `result` at position m and above are zero whenever `done` is high.
- R5: In serial mode (UNROLL=0), if start is accepted at clock edge E, `done` is high for the single cycle after edge E+m.
- R6: In array mode (UNROLL=1), if start is accepted at edge E, `done` is high for the single cycle after edge E+1.
- R7: While an operation is running, `start` is ignored and the captured operands stay unchanged. A start in the cycle where `done` is high is accepted.
- R8: `result` keeps its value from one `done` pulse until the next one.
- R9: A `deg_in` of 0 is treated as degree 1. A `deg_in` above 8 is treated as degree 8.
- R10: With `b_in` equal to x^m mod p(x), that is the low m bits of p, `result` equals A reduced to m bits.
- R11: While reset is high and after it is released, `done` is 0 and `result` is 0 until the first operation finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; inputs are sampled when it is accepted |
| a_in | input | 8 | Operand A, bit i is the coefficient of x^i |
| b_in | input | 8 | Operand B, bit i is the coefficient of x^i |
| poly_in | input | 9 | Field polynomial, bit i is the coefficient of x^i |
| deg_in | input | 4 | Field degree m |
| result | output | 8 | Montgomery product, held between operations |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The bench drives the serial and the array variant side by side. It targets the degree-1 field, the all-zero and all-one operands, and the correction operand that must return A unchanged. A datapath that shifts before reducing, or that runs a fixed 8 steps, would fail these cases for small degrees.

The bench also sets garbage bits above m on the operands and the polynomial, and clears bit m of the polynomial. Logic that does not mask the operands, or that does not force the x^m coefficient, would give wrong products there.

Out-of-range degrees, a start pulse during a running operation, and start held high across consecutive operations probe the controller. A controller that re-captures its inputs mid-operation would corrupt the product, and one that counts steps wrongly would raise `done` in the wrong cycle.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    parameter int GF_MAX_DEG = 8;
    localparam int DEG_W = $clog2(GF_MAX_DEG + 1);
    localparam int IDX_W = (GF_MAX_DEG > 1) ? $clog2(GF_MAX_DEG) : 1;

    typedef logic [GF_MAX_DEG-1:0] gf_elem_t;
    typedef logic [GF_MAX_DEG:0]   gf_poly_t;
    typedef logic [DEG_W-1:0]      deg_t;
    typedef logic [IDX_W-1:0]      idx_t;

    typedef struct packed {
        gf_elem_t a;
        gf_elem_t b;
        gf_poly_t poly;
        deg_t     deg;
    } gf_op_t;

    typedef enum logic {
        GFM_IDLE = 1'b0,
        GFM_RUN  = 1'b1
    } gfm_state_t;

    // Degree limited to 1..GF_MAX_DEG
    function automatic deg_t clamp_deg(deg_t d);
        if (d == '0)
            return deg_t'(1);
        if (int'(d) > GF_MAX_DEG)
            return deg_t'(GF_MAX_DEG);
        return d;
    endfunction

    // Ones in the low d positions
    function automatic gf_elem_t deg_mask(deg_t d);
        gf_elem_t m;
        for (int i = 0; i < GF_MAX_DEG; i++)
            m[i] = (i < int'(d));
        return m;
    endfunction

    // Low d coefficients from the input, x^d forced, rest cleared
    function automatic gf_poly_t form_poly(gf_poly_t p, deg_t d);
        gf_poly_t q;
        for (int i = 0; i <= GF_MAX_DEG; i++)
            q[i] = (i < int'(d)) ? p[i] : (i == int'(d));
        return q;
    endfunction

    // One Montgomery step: add B on bit, make even with p, halve
    function automatic gf_elem_t mont_step(gf_elem_t acc, logic abit,
                                           gf_elem_t b, gf_poly_t p);
        gf_poly_t t;
        t = {1'b0, acc};
        if (abit)
            t = t ^ {1'b0, b};
        if (t[0])
            t = t ^ p;
        return t[GF_MAX_DEG:1];
    endfunction

endpackage

// File: rtl/gfm_capture.sv
module gfm_capture
    import gfm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  gf_elem_t a_in,
    input  gf_elem_t b_in,
    input  gf_poly_t poly_in,
    input  deg_t     deg_in,
    input  logic     core_last,
    output logic     busy,
    output logic     accept,
    output gf_op_t   ops
);

    gfm_state_t state;
    deg_t       deg_c;

    assign deg_c  = clamp_deg(deg_in);
    assign busy   = (state == GFM_RUN);
    assign accept = start && (state == GFM_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GFM_IDLE;
            ops   <= '0;
        end else begin
            case (state)
                GFM_IDLE: begin
                    if (start) begin
                        ops.a    <= a_in & deg_mask(deg_c);
                        ops.b    <= b_in & deg_mask(deg_c);
                        ops.poly <= form_poly(poly_in, deg_c);
                        ops.deg  <= deg_c;
                        state    <= GFM_RUN;
                    end
                end
                GFM_RUN: begin
                    if (core_last)
                        state <= GFM_IDLE;
                end
                default: state <= GFM_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/gfm_serial_core.sv
module gfm_serial_core
    import gfm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     run,
    input  gf_op_t   ops,
    output gf_elem_t val,
    output logic     last
);

    gf_elem_t acc;
    idx_t     idx;

    assign val  = mont_step(acc, ops.a[idx], ops.b, ops.poly);
    assign last = (DEG_W'(idx) == ops.deg - DEG_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            idx <= '0;
        end else if (load) begin
            acc <= '0;
            idx <= '0;
        end else if (run) begin
            acc <= val;
            idx <= idx + idx_t'(1);
        end
    end

endmodule

// File: rtl/gfm_array_core.sv
module gfm_array_core
    import gfm_pkg::*;
(
    input  gf_op_t   ops,
    output gf_elem_t val
);

    gf_elem_t chain [0:GF_MAX_DEG];

    assign chain[0] = '0;

    for (genvar i = 0; i < GF_MAX_DEG; i++) begin : g_stage
        assign chain[i+1] = (i < int'(ops.deg))
                          ? mont_step(chain[i], ops.a[i], ops.b, ops.poly)
                          : chain[i];
    end

    assign val = chain[GF_MAX_DEG];

endmodule

// File: rtl/gf_mont_mul.sv
module gf_mont_mul
    import gfm_pkg::*;
#(
    parameter bit UNROLL = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [GF_MAX_DEG-1:0] a_in,
    input  logic [GF_MAX_DEG-1:0] b_in,
    input  logic [GF_MAX_DEG:0]   poly_in,
    input  logic [DEG_W-1:0]      deg_in,
    output logic [GF_MAX_DEG-1:0] result,
    output logic                  done
);

    logic     busy;
    logic     accept;
    gf_op_t   ops_q;
    gf_elem_t core_val;
    logic     core_last;
    logic     finish;

    gfm_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .a_in      (a_in),
        .b_in      (b_in),
        .poly_in   (poly_in),
        .deg_in    (deg_in),
        .core_last (core_last),
        .busy      (busy),
        .accept    (accept),
        .ops       (ops_q)
    );

    if (UNROLL) begin : g_array
        gfm_array_core u_core (
            .ops (ops_q),
            .val (core_val)
        );
        assign core_last = 1'b1;
    end else begin : g_serial
        gfm_serial_core u_core (
            .clk  (clk),
            .rst  (rst),
            .load (accept),
            .run  (busy),
            .ops  (ops_q),
            .val  (core_val),
            .last (core_last)
        );
    end

    assign finish = busy && core_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (finish)
                result <= core_val & deg_mask(ops_q.deg);
        end
    end

endmodule

// File: rtl/gfm_checker.sv
module gfm_checker
    import gfm_pkg::*;
#(
    parameter bit UNROLL = 1'b0
) (
    input logic     clk,
    input logic     rst,
    input logic     start,
    input logic     busy,
    input logic     done,
    input gf_elem_t result,
    input gf_elem_t cap_a,
    input deg_t     cap_deg
);

    deg_t lat;

    always_ff @(posedge clk) begin
        if (rst)
            lat <= '0;
        else if (start && !busy)
            lat <= '0;
        else if (busy)
            lat <= lat + deg_t'(1);
    end

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((result & ~deg_mask(cap_deg)) == '0));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R5 R6
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat == (UNROLL ? deg_t'(1) : cap_deg)));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(cap_a) && $stable(cap_deg)));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind gf_mont_mul gfm_checker #(.UNROLL(UNROLL)) u_gfm_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .cap_a   (ops_q.a),
    .cap_deg (ops_q.deg)
);

// File: tb/tb_gf_mont_mul.sv
module tb_gf_mont_mul;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] a_in = '0;
    logic [7:0] b_in = '0;
    logic [8:0] poly_in = '0;
    logic [3:0] deg_in = 4'd1;
    logic [7:0] res_s, res_a;
    logic       done_s, done_a;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    int rem      [2];
    int pend     [2];
    bit exp_done [2];
    int exp_res  [2];

    always #2 clk = ~clk;

    gf_mont_mul #(.UNROLL(1'b0)) dut (
        .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
        .poly_in(poly_in), .deg_in(deg_in), .result(res_s), .done(done_s));

    gf_mont_mul #(.UNROLL(1'b1)) dut_arr (
        .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
        .poly_in(poly_in), .deg_in(deg_in), .result(res_a), .done(done_a));

    function automatic int clampd(int d);
        if (d == 0) return 1;
        if (d > 8) return 8;
        return d;
    endfunction

    // Multiply, divide by x m times, then reduce
    function automatic int ref_mont(int a, int b, int p, int d);
        int m = clampd(d);
        int msk = (1 << m) - 1;
        int pe = (p & msk) | (1 << m);
        int am = a & msk;
        int bm = b & msk;
        int c = 0;
        for (int i = 0; i < m; i++)
            if (((bm >> i) & 1) == 1) c = c ^ (am << i);
        for (int k = 0; k < m; k++) begin
            if ((c & 1) == 1) c = c ^ pe;
            c = c >> 1;
        end
        for (int bt = 2 * m; bt >= m; bt--)
            if (((c >> bt) & 1) == 1) c = c ^ (pe << (bt - m));
        return c;
    endfunction

    // Behavioural model of both variants
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                rem[k] = 0;
                exp_done[k] = 1'b0;
                exp_res[k] = 0;
            end else begin
                exp_done[k] = 1'b0;
                if (rem[k] > 0) begin
                    rem[k] = rem[k] - 1;
                    if (rem[k] == 0) begin
                        exp_done[k] = 1'b1;
                        exp_res[k] = pend[k];
                    end
                end else if (start) begin
                    rem[k] = (k == 0) ? clampd(int'(deg_in)) : 1;
                    pend[k] = ref_mont(int'(a_in), int'(b_in), int'(poly_in), int'(deg_in));
                end
            end
        end
    end

    task automatic chk(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            chk("R11 done_s", int'(done_s), 0);
            chk("R11 done_a", int'(done_a), 0);
            chk("R11 res_s", int'(res_s), 0);
            chk("R11 res_a", int'(res_a), 0);
        end else begin
            chk("R5 done serial", int'(done_s), int'(exp_done[0]));
            chk("R6 done array", int'(done_a), int'(exp_done[1]));
            chk(exp_done[0] ? {cur_tag, " serial"} : "R8 serial", int'(res_s), exp_res[0]);
            chk(exp_done[1] ? {cur_tag, " array"} : "R8 array", int'(res_a), exp_res[1]);
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (rem[0] != 0 || rem[1] != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue(string tag, int a, int b, int p, int d);
        cur_tag = tag;
        @(negedge clk);
        a_in = 8'(a); b_in = 8'(b); poly_in = 9'(p); deg_in = 4'(d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
    endtask

    int prim [9] = '{0, 'h3, 'h7, 'hB, 'h13, 'h25, 'h43, 'h89, 'h11D};

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 idle done", int'(done_s), 0);

        // R1 degree one field
        issue("R1", 1, 1, 'h3, 1);
        issue("R1", 1, 0, 'h3, 1);

        for (int m = 2; m <= 8; m++) begin
            int msk = (1 << m) - 1;
            issue("R1", 0, 'h5 & msk, prim[m], m);
            issue("R1", msk, 0, prim[m], m);
            issue("R1", 1, msk, prim[m], m);
            issue("R4", msk, msk, prim[m], m);
            // R10 correction operand returns A
            issue("R10", 'h5A & msk, prim[m] & msk, prim[m], m);
            for (int r = 0; r < 12; r++)
                issue("R1", int'($urandom) & msk, int'($urandom) & msk, prim[m], m);
        end

        // R2 other degree-8 polynomials and garbage upper bits
        for (int r = 0; r < 6; r++) begin
            issue("R2", int'($urandom) & 'hFF, int'($urandom) & 'hFF, 'h12B, 8);
            issue("R2", int'($urandom) & 'hFF, int'($urandom) & 'hFF, 'h165, 8);
        end
        issue("R2", 'h9, 'hD, 'h1E3, 4);
        issue("R2", 'h3, 'h6, 'h1F3, 3);

        // R3 operand bits above m
        for (int r = 0; r < 6; r++)
            issue("R3", int'($urandom) & 'hFF, int'($urandom) & 'hFF, prim[3], 3);

        // R9 degree clamping
        issue("R9", 'hFF, 'hFF, 'h3, 0);
        issue("R9", 'hA7, 'h3C, prim[8], 15);
        issue("R9", 'h5B, 'hC1, prim[8], 9);

        // R7 start during a running operation
        cur_tag = "R7";
        @(negedge clk);
        a_in = 8'hC3; b_in = 8'h77; poly_in = 9'h11D; deg_in = 4'd8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        a_in = 8'h11; b_in = 8'h22; poly_in = 9'h12B; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        // R7 start held high across operations
        @(negedge clk);
        for (int c = 0; c < 30; c++) begin
            a_in = 8'($urandom); b_in = 8'($urandom);
            poly_in = 9'h7; deg_in = 4'd2; start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        wait_idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule